// File: doc/BRIEF.md
# USB Endpoint Interrupt Router

This block sits beside the packet engine of a USB device controller. It turns per-endpoint completion strobes into sticky status bits and folds those bits into device-level status and one interrupt request line. Endpoints alternate by index. Even indices are OUT endpoints and odd indices are IN endpoints. A parameter mask marks the isochronous endpoints, which raise no per-packet events. For those endpoints a prescaled frame tick sets a FRAME status bit once per millisecond instead.

Each endpoint has three register bits: an enable bit, a sticky status bit and a class bit. The class bit sends a pending status to either a fast aggregate or a slow aggregate. A separate bank of system-error status bits shares the same write-one-to-set and write-one-to-clear scheme. Software uses a plain word-addressed register port. Writes take effect on the next rising clock edge and reads are combinational from the address.

Top module: `usb_ep_irq_router`

## Requirements
- R1: An OUT endpoint (even index, not isochronous) raises an event only on its `ep_rx_ok` strobe. Its `ep_tx_ok` and `ep_nak` strobes have no effect.
- R2: An IN endpoint (odd index, not isochronous) raises an event on its `ep_tx_ok` strobe. It raises one on its `ep_nak` strobe only while bit 0 of the mode register (address 8) is 1. Its `ep_rx_ok` strobe has no effect.
- R3: An event sets the endpoint's status bit (read at address 0) only when that endpoint's bit in the enable register (address 3) is 1. The bit is set on the clock edge that samples the strobe.
- R4: `dev_status[1]` is the OR of the enabled pending statuses whose class bit (address 4) is 1 (fast). `dev_status[2]` is the same OR over the endpoints whose class bit is 0 (slow). Both are readable at address 5.
- R5: Endpoints marked in `ISO_MASK` never set status. `dev_status[0]` (FRAME) is sticky and is set every `FRAME_CYCLES` clocks. Writing 1 to bit 0 at address 6 clears it.
- R6: `irq_lp` is high exactly when some bit of `dev_status` is high and its bit in the device enable register (address 7) is also high.
- R7: Writing 1s to the system-error set register (address 11) sets the matching status bits, which are read at address 9. Zero bits leave their status unchanged, and the set register reads as 0.
- R8: Writing 1s to the system-error clear register (address 10) clears the matching bits. Status bits below index `SERR_FIRST` (default 2) do not exist and always read 0.
- R9: When a qualified event and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R10: Endpoint status has a write-one-to-clear register (address 1) and a write-one-to-set register (address 2). Both read as 0. The set register works whatever the enable bit is.
- R11: After reset, every status, enable, class, device-enable and mode bit is 0, and `irq_lp` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ep_rx_ok | input | NUM_EP | One-cycle strobe: error-free packet received |
| ep_tx_ok | input | NUM_EP | One-cycle strobe: packet transmitted |
| ep_nak | input | NUM_EP | One-cycle strobe: NAK sent |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| dev_status | output | 3 | {slow, fast, frame} device status |
| irq_lp | output | 1 | Low-priority interrupt request |

## Verification
A lost or spurious endpoint status bit shows up the next cycle in two places: the status word at address 0 and, through the fast or slow aggregate, `dev_status` and `irq_lp` in that same cycle. A class bit that steers a status into the wrong aggregate appears at once, because the opposite `dev_status` bit rises. A prescaler that drifts is only visible at the next FRAME rise, up to `FRAME_CYCLES` clocks later. For that reason the gap between two rises is measured directly. Damage in the system-error bank is visible only through its read-back word.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

   localparam int REG_AW = 4;
   localparam int DEV_W  = 3;

   localparam int DEV_FRAME = 0;
   localparam int DEV_FAST  = 1;
   localparam int DEV_SLOW  = 2;

   typedef enum logic [REG_AW-1:0] {
      RA_EP_STAT   = 4'd0,
      RA_EP_CLR    = 4'd1,
      RA_EP_SET    = 4'd2,
      RA_EP_EN     = 4'd3,
      RA_EP_PRI    = 4'd4,
      RA_DEV_STAT  = 4'd5,
      RA_DEV_CLR   = 4'd6,
      RA_DEV_EN    = 4'd7,
      RA_MODE      = 4'd8,
      RA_SERR_STAT = 4'd9,
      RA_SERR_CLR  = 4'd10,
      RA_SERR_SET  = 4'd11
   } reg_addr_e;

endpackage

// File: rtl/usb_irq_w1_bank.sv
module usb_irq_w1_bank #(
   parameter int             W         = 32,
   parameter logic [W-1:0]   IMPL_MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] hw_set,
   input  logic [W-1:0] sw_set,
   input  logic [W-1:0] sw_clr,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("usb_irq_w1_bank: W must be at least 1");
   end

   logic [W-1:0] nxt;

   always_comb begin
      nxt = (q & ~sw_clr) | sw_set | hw_set;
      nxt = nxt & IMPL_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

endmodule

// File: rtl/usb_irq_ep_qual.sv
module usb_irq_ep_qual #(
   parameter int                NUM_EP   = 32,
   parameter logic [NUM_EP-1:0] ISO_MASK = '0
) (
   input  logic [NUM_EP-1:0] rx_ok,
   input  logic [NUM_EP-1:0] tx_ok,
   input  logic [NUM_EP-1:0] nak,
   input  logic              nak_mode,
   input  logic [NUM_EP-1:0] ep_en,
   output logic [NUM_EP-1:0] ev_set
);

   logic unused_in;
   assign unused_in = ^{rx_ok, tx_ok, nak};

   for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
      if (ISO_MASK[g]) begin : g_iso
         assign ev_set[g] = 1'b0;
      end else if ((g % 2) == 0) begin : g_out
         assign ev_set[g] = rx_ok[g] & ep_en[g];
      end else begin : g_in
         assign ev_set[g] = (tx_ok[g] | (nak[g] & nak_mode)) & ep_en[g];
      end
   end

endmodule

// File: rtl/usb_irq_frame_div.sv
module usb_irq_frame_div #(
   parameter int CYCLES = 48000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);

   localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

   if (CYCLES < 2) begin : g_bad_cycles
      $error("usb_irq_frame_div: CYCLES must be at least 2");
   end

   logic [CW-1:0] cnt;

   assign tick = (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/usb_ep_irq_router.sv
module usb_ep_irq_router
   import usb_irq_pkg::*;
#(
   parameter int                NUM_EP       = 32,
   parameter int                DATA_W       = 32,
   parameter int                FRAME_CYCLES = 48000,
   parameter logic [NUM_EP-1:0] ISO_MASK     = NUM_EP'(32'h0000_00C0),
   parameter int                SERR_FIRST   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_EP-1:0] ep_rx_ok,
   input  logic [NUM_EP-1:0] ep_tx_ok,
   input  logic [NUM_EP-1:0] ep_nak,
   input  logic              reg_wr,
   input  logic [3:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [2:0]        dev_status,
   output logic              irq_lp
);

   localparam logic [NUM_EP-1:0] SERR_IMPL = {NUM_EP{1'b1}} << SERR_FIRST;

   if (NUM_EP > DATA_W) begin : g_bad_width
      $error("usb_ep_irq_router: NUM_EP must not exceed DATA_W");
   end
   if (NUM_EP < 2) begin : g_bad_ep
      $error("usb_ep_irq_router: at least one OUT and one IN endpoint");
   end
   if (SERR_FIRST < 0 || SERR_FIRST >= NUM_EP) begin : g_bad_serr
      $error("usb_ep_irq_router: SERR_FIRST out of range");
   end

   // register write decode
   logic wr_ep_clr, wr_ep_set, wr_ep_en, wr_ep_pri;
   logic wr_dev_clr, wr_dev_en, wr_mode, wr_serr_clr, wr_serr_set;

   always_comb begin
      wr_ep_clr   = reg_wr && (reg_addr == RA_EP_CLR);
      wr_ep_set   = reg_wr && (reg_addr == RA_EP_SET);
      wr_ep_en    = reg_wr && (reg_addr == RA_EP_EN);
      wr_ep_pri   = reg_wr && (reg_addr == RA_EP_PRI);
      wr_dev_clr  = reg_wr && (reg_addr == RA_DEV_CLR);
      wr_dev_en   = reg_wr && (reg_addr == RA_DEV_EN);
      wr_mode     = reg_wr && (reg_addr == RA_MODE);
      wr_serr_clr = reg_wr && (reg_addr == RA_SERR_CLR);
      wr_serr_set = reg_wr && (reg_addr == RA_SERR_SET);
   end

   logic [NUM_EP-1:0] wd_ep;
   assign wd_ep = reg_wdata[NUM_EP-1:0];

   logic unused_wdata;
   assign unused_wdata = ^reg_wdata;

   // configuration registers
   logic [NUM_EP-1:0] ep_en, ep_pri;
   logic [DEV_W-1:0]  dev_en;
   logic              nak_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ep_en    <= '0;
         ep_pri   <= '0;
         dev_en   <= '0;
         nak_mode <= 1'b0;
      end else begin
         if (wr_ep_en)  ep_en    <= wd_ep;
         if (wr_ep_pri) ep_pri   <= wd_ep;
         if (wr_dev_en) dev_en   <= reg_wdata[DEV_W-1:0];
         if (wr_mode)   nak_mode <= reg_wdata[0];
      end
   end

   // endpoint event qualification
   logic [NUM_EP-1:0] ep_qual;

   usb_irq_ep_qual #(
      .NUM_EP   (NUM_EP),
      .ISO_MASK (ISO_MASK)
   ) u_qual (
      .rx_ok    (ep_rx_ok),
      .tx_ok    (ep_tx_ok),
      .nak      (ep_nak),
      .nak_mode (nak_mode),
      .ep_en    (ep_en),
      .ev_set   (ep_qual)
   );

   // endpoint status bank
   logic [NUM_EP-1:0] ep_stat, ep_sw_set, ep_sw_clr;
   assign ep_sw_set = wr_ep_set ? wd_ep : '0;
   assign ep_sw_clr = wr_ep_clr ? wd_ep : '0;

   usb_irq_w1_bank #(
      .W         (NUM_EP),
      .IMPL_MASK ({NUM_EP{1'b1}})
   ) u_ep_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .hw_set (ep_qual),
      .sw_set (ep_sw_set),
      .sw_clr (ep_sw_clr),
      .q      (ep_stat)
   );

   // frame tick and sticky frame bit
   logic frame_tick, frame_q;

   usb_irq_frame_div #(
      .CYCLES (FRAME_CYCLES)
   ) u_frame (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (frame_tick)
   );

   usb_irq_w1_bank #(
      .W         (1),
      .IMPL_MASK (1'b1)
   ) u_frame_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .hw_set (frame_tick),
      .sw_set (1'b0),
      .sw_clr (wr_dev_clr & reg_wdata[DEV_FRAME]),
      .q      (frame_q)
   );

   // system-error bank
   logic [NUM_EP-1:0] serr_stat;

   usb_irq_w1_bank #(
      .W         (NUM_EP),
      .IMPL_MASK (SERR_IMPL)
   ) u_serr_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .hw_set ('0),
      .sw_set (wr_serr_set ? wd_ep : '0),
      .sw_clr (wr_serr_clr ? wd_ep : '0),
      .q      (serr_stat)
   );

   // fast / slow aggregation
   logic [NUM_EP-1:0] pend;
   logic              agg_fast, agg_slow;

   always_comb begin
      pend     = ep_stat & ep_en;
      agg_fast = |(pend & ep_pri);
      agg_slow = |(pend & ~ep_pri);
   end

   always_comb begin
      dev_status            = '0;
      dev_status[DEV_FRAME] = frame_q;
      dev_status[DEV_FAST]  = agg_fast;
      dev_status[DEV_SLOW]  = agg_slow;
   end

   assign irq_lp = |(dev_status & dev_en);

   // read mux
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_EP_STAT:   reg_rdata = DATA_W'(ep_stat);
         RA_EP_EN:     reg_rdata = DATA_W'(ep_en);
         RA_EP_PRI:    reg_rdata = DATA_W'(ep_pri);
         RA_DEV_STAT:  reg_rdata = DATA_W'(dev_status);
         RA_DEV_EN:    reg_rdata = DATA_W'(dev_en);
         RA_MODE:      reg_rdata = DATA_W'(nak_mode);
         RA_SERR_STAT: reg_rdata = DATA_W'(serr_stat);
         default:      reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/usb_ep_irq_router_chk.sv
module usb_ep_irq_router_chk
   import usb_irq_pkg::*;
#(
   parameter int                NUM_EP       = 32,
   parameter int                DATA_W       = 32,
   parameter int                FRAME_CYCLES = 48000,
   parameter logic [NUM_EP-1:0] ISO_MASK     = '0,
   parameter int                SERR_FIRST   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [3:0]        reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [2:0]        dev_status,
   input logic              irq_lp,
   input logic [NUM_EP-1:0] ep_stat,
   input logic [NUM_EP-1:0] ep_en,
   input logic [NUM_EP-1:0] ep_pri,
   input logic [NUM_EP-1:0] ep_qual,
   input logic [NUM_EP-1:0] ep_sw_set,
   input logic [NUM_EP-1:0] serr_stat,
   input logic [2:0]        dev_en,
   input logic              frame_tick
);

   localparam logic [NUM_EP-1:0] SERR_IMPL = {NUM_EP{1'b1}} << SERR_FIRST;
   localparam int GW = $clog2(FRAME_CYCLES + 1) + 1;

   logic [GW-1:0] gap;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          gap <= '0;
      else if (frame_tick) gap <= '0;
      else                 gap <= gap + 1'b1;
   end

   logic [NUM_EP-1:0] wd_ep;
   assign wd_ep = reg_wdata[NUM_EP-1:0];

   AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (ep_qual != '0) |=> ((ep_stat & $past(ep_qual)) == $past(ep_qual))); // R9

   AST_ENABLE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      ((ep_qual & ~ep_en) == '0) |=>
      ((ep_stat & ~$past(ep_stat) & ~$past(ep_en) & ~$past(ep_sw_set)) == '0)); // R3

   AST_ISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((ep_qual & ISO_MASK) == '0)); // R5

   AST_FAST_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      dev_status[DEV_FAST] |-> ((ep_stat & ep_en & ep_pri) != '0)); // R4

   AST_SLOW_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      dev_status[DEV_SLOW] |-> ((ep_stat & ep_en & ~ep_pri) != '0)); // R4

   AST_FRAME_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      frame_tick |-> (gap == GW'(FRAME_CYCLES - 1))); // R5

   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      irq_lp |-> ((dev_status & dev_en) != '0)); // R6

   AST_SERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == RA_SERR_SET) |=>
      ((serr_stat & $past(wd_ep & SERR_IMPL)) == $past(wd_ep & SERR_IMPL))); // R7

   AST_SERR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == RA_SERR_CLR) |=>
      ((serr_stat & $past(wd_ep)) == '0)); // R8

   AST_SERR_LOW_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
      ((serr_stat & ~SERR_IMPL) == '0)); // R8

endmodule

bind usb_ep_irq_router usb_ep_irq_router_chk #(
   .NUM_EP       (NUM_EP),
   .DATA_W       (DATA_W),
   .FRAME_CYCLES (FRAME_CYCLES),
   .ISO_MASK     (ISO_MASK),
   .SERR_FIRST   (SERR_FIRST)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .reg_addr   (reg_addr),
   .reg_wdata  (reg_wdata),
   .dev_status (dev_status),
   .irq_lp     (irq_lp),
   .ep_stat    (ep_stat),
   .ep_en      (ep_en),
   .ep_pri     (ep_pri),
   .ep_qual    (ep_qual),
   .ep_sw_set  (ep_sw_set),
   .serr_stat  (serr_stat),
   .dev_en     (dev_en),
   .frame_tick (frame_tick)
);

// File: tb/tb_usb_ep_irq_router.sv
module tb_usb_ep_irq_router;

   localparam int NUM_EP = 32;
   localparam int DATA_W = 32;
   localparam int FRAME_CYCLES = 50;
   localparam logic [31:0] ISO = 32'h0000_00C0;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NUM_EP-1:0] ep_rx_ok = '0, ep_tx_ok = '0, ep_nak = '0;
   logic              reg_wr = 1'b0;
   logic [3:0]        reg_addr = '0;
   logic [DATA_W-1:0] reg_wdata = '0;
   logic [DATA_W-1:0] reg_rdata;
   logic [2:0]        dev_status;
   logic              irq_lp;

   always #2 clk = ~clk;

   usb_ep_irq_router #(
      .NUM_EP       (NUM_EP),
      .DATA_W       (DATA_W),
      .FRAME_CYCLES (FRAME_CYCLES),
      .ISO_MASK     (ISO),
      .SERR_FIRST   (2)
   ) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ep_rx_ok   (ep_rx_ok),
      .ep_tx_ok   (ep_tx_ok),
      .ep_nak     (ep_nak),
      .reg_wr     (reg_wr),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .dev_status (dev_status),
      .irq_lp     (irq_lp)
   );

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   // kind: 0 rx_ok, 1 tx_ok, 2 nak
   task automatic strobe(input int ep, input int kind);
      @(negedge clk);
      case (kind)
         0: ep_rx_ok[ep] = 1'b1;
         1: ep_tx_ok[ep] = 1'b1;
         default: ep_nak[ep] = 1'b1;
      endcase
      @(negedge clk);
      ep_rx_ok = '0; ep_tx_ok = '0; ep_nak = '0;
   endtask

   typedef struct packed {
      logic [4:0] ep;
      logic [1:0] kind;
      logic       en;
      logic       mode;
      logic       pri;
      logic       exp;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{5'd4,  2'd0, 1'b1, 1'b0, 1'b0, 1'b1},  // R1 OUT rx, slow
      '{5'd4,  2'd0, 1'b0, 1'b0, 1'b0, 1'b0},  // R3 disabled
      '{5'd5,  2'd1, 1'b1, 1'b0, 1'b1, 1'b1},  // R2 IN tx, fast
      '{5'd5,  2'd2, 1'b1, 1'b0, 1'b1, 1'b0},  // R2 nak, mode off
      '{5'd5,  2'd2, 1'b1, 1'b1, 1'b1, 1'b1},  // R2 nak, mode on
      '{5'd4,  2'd1, 1'b1, 1'b0, 1'b0, 1'b0},  // R1 tx on OUT ignored
      '{5'd5,  2'd0, 1'b1, 1'b0, 1'b1, 1'b0},  // R2 rx on IN ignored
      '{5'd6,  2'd0, 1'b1, 1'b0, 1'b0, 1'b0},  // R5 iso OUT
      '{5'd7,  2'd1, 1'b1, 1'b0, 1'b1, 1'b0},  // R5 iso IN
      '{5'd31, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1},  // R2 top IN, fast
      '{5'd0,  2'd0, 1'b1, 1'b0, 1'b0, 1'b1},  // R1 bottom OUT, slow
      '{5'd2,  2'd2, 1'b1, 1'b1, 1'b0, 1'b0}   // R1 nak on OUT ignored
   };

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: act=timeout exp=finish");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      int t1, t2;

      repeat (3) @(negedge clk);
      // R11 reset state
      rd(4'd0, d);  chk("R11 ep status", d, 32'h0);
      rd(4'd3, d);  chk("R11 ep enable", d, 32'h0);
      rd(4'd4, d);  chk("R11 ep class", d, 32'h0);
      rd(4'd7, d);  chk("R11 dev enable", d, 32'h0);
      rd(4'd8, d);  chk("R11 mode", d, 32'h0);
      rd(4'd9, d);  chk("R11 serr", d, 32'h0);
      chk("R11 irq", {31'h0, irq_lp}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      rd(4'd0, d);  chk("R11 ep status after release", d, 32'h0);
      chk("R11 fast/slow idle", {29'h0, dev_status & 3'b110}, 32'h0);

      // table-driven endpoint events
      wr(4'd7, 32'h2);  // irq follows fast only
      for (int i = 0; i < NV; i++) begin
         vec_t v;
         logic [31:0] bitm;
         v = VECS[i];
         bitm = 32'h1 << v.ep;
         wr(4'd1, 32'hFFFF_FFFF);
         wr(4'd3, v.en ? bitm : 32'h0);
         wr(4'd4, v.pri ? bitm : 32'h0);
         wr(4'd8, {31'h0, v.mode});
         strobe(int'(v.ep), int'(v.kind));
         rd(4'd0, d);
         chk($sformatf("R1/R2/R3/R5 vec%0d status", i), d, v.exp ? bitm : 32'h0);
         chk($sformatf("R4 vec%0d fast", i), {31'h0, dev_status[1]}, {31'h0, v.exp & v.pri});
         chk($sformatf("R4 vec%0d slow", i), {31'h0, dev_status[2]}, {31'h0, v.exp & ~v.pri});
         chk($sformatf("R6 vec%0d irq", i), {31'h0, irq_lp}, {31'h0, v.exp & v.pri});
      end

      // R9 event against clear in the same cycle
      wr(4'd1, 32'hFFFF_FFFF);
      wr(4'd3, 32'h0000_0100);
      @(negedge clk);
      ep_rx_ok[8] = 1'b1;
      reg_wr = 1'b1; reg_addr = 4'd1; reg_wdata = 32'h0000_0100;
      @(negedge clk);
      ep_rx_ok = '0; reg_wr = 1'b0; reg_wdata = '0;
      rd(4'd0, d);  chk("R9 event beats clear", d, 32'h0000_0100);
      wr(4'd1, 32'h0000_0100);
      rd(4'd0, d);  chk("R10 clear alone", d, 32'h0);

      // R10 software set ignores enable; set/clear read zero
      wr(4'd3, 32'h0);
      wr(4'd2, 32'h0000_0200);
      rd(4'd0, d);  chk("R10 sw set", d, 32'h0000_0200);
      chk("R4 disabled not aggregated", {29'h0, dev_status & 3'b110}, 32'h0);
      rd(4'd2, d);  chk("R10 set reads 0", d, 32'h0);
      rd(4'd1, d);  chk("R10 clear reads 0", d, 32'h0);
      wr(4'd1, 32'h0000_0200);

      // R7 / R8 system-error bank
      wr(4'd11, 32'hFFFF_FFFF);
      rd(4'd9, d);  chk("R8 low bits absent", d, 32'hFFFF_FFFC);
      rd(4'd11, d); chk("R7 set reads 0", d, 32'h0);
      wr(4'd10, 32'h0000_00F0);
      rd(4'd9, d);  chk("R8 clear", d, 32'hFFFF_FF0C);
      wr(4'd11, 32'h0);
      rd(4'd9, d);  chk("R7 zero set no effect", d, 32'hFFFF_FF0C);
      wr(4'd10, 32'h0);
      rd(4'd9, d);  chk("R8 zero clear no effect", d, 32'hFFFF_FF0C);
      wr(4'd10, 32'hFFFF_FFFF);
      rd(4'd9, d);  chk("R8 all cleared", d, 32'h0);

      // R5 frame period
      wr(4'd6, 32'h1);
      t1 = -1; t2 = -1;
      for (int k = 0; k < 200 && t1 < 0; k++) begin
         @(negedge clk);
         if (dev_status[0]) t1 = cyc;
      end
      wr(4'd6, 32'h1);
      for (int k = 0; k < 200 && t2 < 0; k++) begin
         @(negedge clk);
         if (dev_status[0]) t2 = cyc;
      end
      chk("R5 frame found", {31'h0, (t1 >= 0) && (t2 >= 0)}, 32'h1);
      chk("R5 frame period", t2 - t1, FRAME_CYCLES);
      rd(4'd5, d);  chk("R5 frame readable", d & 32'h1, 32'h1);

      // R6 interrupt follows device enable
      wr(4'd7, 32'h1);
      chk("R6 irq on frame", {31'h0, irq_lp}, 32'h1);
      wr(4'd7, 32'h0);
      chk("R6 irq masked", {31'h0, irq_lp}, 32'h0);

      finish_run();
   end

endmodule